// File: doc/BRIEF.md
# Packed-Control Event Counter Bank

This block is a bank of four 32-bit event counters behind a simple register bus made of an address, a write strobe, write data and combinational read data. A single 32-bit control word packs one byte per counter. Within its byte, each counter keeps a 5-bit event code in bits [5:1]. The code chooses what the counter counts. Code 0 parks the counter. Code 1 counts every clock cycle. Codes 2 to 15 count the cycles in which the matching bit of the event-strobe input is high; for example, bit 11 might carry write transactions, bit 13 data transfers and bit 15 read transactions. Codes 16 to 31 have no event source, so the counter holds its value.

Each counter has a data register at its own address. Software reads the count from it, and a write loads the count (writing zero clears it). There is no overflow indication: a counter wraps from all-ones to zero. The counters must be sampled often enough that no more than one wrap goes unseen.

Each counter lane is a small state machine with three states. LANE_IDLE holds the count. LANE_COUNT adds one whenever the selected source is active. LANE_MUTE holds a non-zero code that has no source. A control write moves every lane at once, using the code in that lane's byte. Transition T_PARK goes to LANE_IDLE on code 0. T_ARM goes to LANE_COUNT on codes 1 to 15. T_MUTE goes to LANE_MUTE on codes 16 to 31. Without a control write a lane stays in its state. The new state governs counting from the clock edge after the write edge.

Top module: `ecb_bank`

## Requirements
- R1: After reset every counter reads 0, the control word reads 0 and every lane is in LANE_IDLE.
- R2: The control word at address 0x234 reads back each lane's code at bits [8n+5:8n+1] and zero in every other bit; the write data in those other bits is discarded.
- R3: A lane with code 0 holds its count whatever its event inputs do.
- R4: A lane with code 1 adds one on every clock edge.
- R5: A lane with code k in 2..15 adds one on each edge at which ev_i[k] is high. A code written on one edge first governs counting on the next edge.
- R6: A lane with a code in 16..31 holds its count, and its code still reads back unchanged.
- R7: A counter at 0xFFFFFFFF that counts one more event reads 0, and nothing else signals the wrap.
- R8: A write to lane n's data register at 0x240 + 0xC*n loads the written value (zero clears the count), and it takes priority over an event counted at the same edge.
- R9: Reads of any address other than the control word and the four data registers return 0, and writes to them change no count and no code.
- R10: A data write to one lane leaves the counts of the other lanes following their own codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| ev_i | input | 16 | Event strobes; bit k is the source for code k (bits 0 and 1 unused) |

## Verification
If a lane's code register or state were wrong, the readback of the control word would show it at once, and the lane's data register would drift from the expected count within one cycle of the first event the lane should or should not have counted. A wrong address decode shows up as a non-zero read of an unmapped address, or as a count loaded in the wrong lane, on the read right after the write. Random control words that cover all 32 codes, mixed with data writes and random strobes, are checked after every cycle. This bounds the delay before any such fault is seen to a single clock.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
    localparam int REG_W     = 32;
    localparam int CODE_W    = 5;
    localparam int FIELD_LSB = 1;
    localparam int LANE_BITS = 8;
    localparam int EXT_W     = 1 << CODE_W;
    localparam logic [CODE_W-1:0] CODE_PARK  = '0;
    localparam logic [CODE_W-1:0] CODE_CYCLE = CODE_W'(1);

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_COUNT = 2'd1,
        LANE_MUTE  = 2'd2
    } lane_state_e;
endpackage

// File: rtl/ecb_decode.sv
module ecb_decode #(
    parameter int ADDR_W      = 12,
    parameter int NUM_CTR     = 4,
    parameter int CTL_ADDR    = 'h234,
    parameter int DATA_BASE   = 'h240,
    parameter int DATA_STRIDE = 'h00C
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    output logic               ctl_hit_o,
    output logic               ctl_wr_o,
    output logic [NUM_CTR-1:0] data_hit_o,
    output logic [NUM_CTR-1:0] data_wr_o,
    output logic               any_hit_o
);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    assign ctl_hit_o = (addr_i == CTL_A);
    assign ctl_wr_o  = ctl_hit_o & wr_en_i;

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_data_dec
        localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_BASE + n * DATA_STRIDE);
        assign data_hit_o[n] = (addr_i == DATA_A);
        assign data_wr_o[n]  = data_hit_o[n] & wr_en_i;
    end

    assign any_hit_o = ctl_hit_o | (|data_hit_o);
endmodule

// File: rtl/ecb_lane.sv
module ecb_lane
    import ecb_pkg::*;
#(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    input  logic              ld_i,
    input  logic [CTR_W-1:0]  ld_val_i,
    input  logic [NUM_EVT-1:0] ev_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CTR_W-1:0]  cnt_o
);
    lane_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CTR_W-1:0]  cnt_q;
    logic [EXT_W-1:0]  src_vec;
    logic              bump;

    // Source vector indexed by code; code 1 is the free-running cycle source.
    always_comb begin
        src_vec = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            src_vec[k] = ev_i[k];
        end
        src_vec[CODE_CYCLE] = 1'b1;
    end

    // Next state: only a control write moves the lane (T_PARK, T_ARM, T_MUTE).
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (cfg_wr_i) begin
            code_d = cfg_code_i;
            if (cfg_code_i == CODE_PARK) begin
                state_d = LANE_IDLE;
            end else if (int'(cfg_code_i) < NUM_EVT) begin
                state_d = LANE_COUNT;
            end else begin
                state_d = LANE_MUTE;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
            code_q  <= CODE_PARK;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Output decision per state.
    always_comb begin
        bump = 1'b0;
        unique case (state_q)
            LANE_IDLE:  bump = 1'b0;
            LANE_COUNT: bump = src_vec[code_q];
            LANE_MUTE:  bump = 1'b0;
            default:    bump = 1'b0;
        endcase
    end

    // Count register: a software load beats an event on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (bump) begin
            cnt_q <= cnt_q + CTR_W'(1);
        end
    end

    assign code_o = code_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/ecb_rdmux.sv
module ecb_rdmux
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32
) (
    input  logic                            ctl_hit_i,
    input  logic [NUM_CTR-1:0]              data_hit_i,
    input  logic [NUM_CTR-1:0][CODE_W-1:0]  code_i,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]   cnt_i,
    output logic [REG_W-1:0]                rd_data_o
);
    logic [REG_W-1:0] ctl_word;

    always_comb begin
        ctl_word = '0;
        for (int n = 0; n < NUM_CTR; n++) begin
            ctl_word[n*LANE_BITS + FIELD_LSB +: CODE_W] = code_i[n];
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (ctl_hit_i) begin
            rd_data_o = ctl_word;
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            if (data_hit_i[n]) begin
                rd_data_o = REG_W'(cnt_i[n]);
            end
        end
    end
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
    import ecb_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_CTR     = 4,
    parameter int CTR_W       = 32,
    parameter int NUM_EVT     = 16,
    parameter int CTL_ADDR    = 'h234,
    parameter int DATA_BASE   = 'h240,
    parameter int DATA_STRIDE = 'h00C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic [NUM_EVT-1:0] ev_i
);
    logic                           ctl_hit, ctl_wr, any_hit;
    logic [NUM_CTR-1:0]             data_hit_sel, data_wr_sel;
    logic [NUM_CTR-1:0][CODE_W-1:0] lane_code;
    logic [NUM_CTR-1:0][CTR_W-1:0]  lane_cnt;

    ecb_decode #(
        .ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR), .CTL_ADDR(CTL_ADDR),
        .DATA_BASE(DATA_BASE), .DATA_STRIDE(DATA_STRIDE)
    ) u_decode (
        .addr_i(addr_i), .wr_en_i(wr_en_i),
        .ctl_hit_o(ctl_hit), .ctl_wr_o(ctl_wr),
        .data_hit_o(data_hit_sel), .data_wr_o(data_wr_sel),
        .any_hit_o(any_hit)
    );

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_lane
        ecb_lane #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .cfg_wr_i(ctl_wr),
            .cfg_code_i(wr_data_i[n*LANE_BITS + FIELD_LSB +: CODE_W]),
            .ld_i(data_wr_sel[n]),
            .ld_val_i(wr_data_i[CTR_W-1:0]),
            .ev_i(ev_i),
            .code_o(lane_code[n]),
            .cnt_o(lane_cnt[n])
        );
    end

    ecb_rdmux #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_rdmux (
        .ctl_hit_i(ctl_hit), .data_hit_i(data_hit_sel),
        .code_i(lane_code), .cnt_i(lane_cnt),
        .rd_data_o(rd_data_o)
    );
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [REG_W-1:0]               wr_data_i,
    input logic [REG_W-1:0]               rd_data_o,
    input logic                           ctl_hit,
    input logic                           any_hit,
    input logic [NUM_CTR-1:0]             data_wr_sel,
    input logic [NUM_CTR-1:0][CODE_W-1:0] lane_code,
    input logic [NUM_CTR-1:0][CTR_W-1:0]  lane_cnt
);
    logic [REG_W-1:0] rsv_mask;
    always_comb begin
        rsv_mask = '1;
        for (int n = 0; n < NUM_CTR; n++) begin
            rsv_mask[n*LANE_BITS + FIELD_LSB +: CODE_W] = 1'b0;
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> rd_data_o == '0); // R9

    AST_CTL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hit |-> (rd_data_o & rsv_mask) == '0); // R2

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_lane_chk
        AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_code[n] == CODE_PARK && !data_wr_sel[n])
            |=> lane_cnt[n] == $past(lane_cnt[n])); // R3

        AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_code[n] == CODE_CYCLE && !data_wr_sel[n])
            |=> lane_cnt[n] == CTR_W'($past(lane_cnt[n]) + CTR_W'(1))); // R4

        AST_MUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(lane_code[n]) >= NUM_EVT && !data_wr_sel[n])
            |=> lane_cnt[n] == $past(lane_cnt[n])); // R6

        AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            data_wr_sel[n] |=> lane_cnt[n] == $past(wr_data_i[CTR_W-1:0])); // R8
    end
endmodule

bind ecb_bank ecb_bank_chk #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .NUM_EVT(NUM_EVT)
) u_ecb_bank_chk (
    .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .ctl_hit(ctl_hit), .any_hit(any_hit), .data_wr_sel(data_wr_sel),
    .lane_code(lane_code), .lane_cnt(lane_cnt)
);

// File: tb/test_ecb_bank.sv
`timescale 1ns/1ps
module test_ecb_bank;
    localparam int CLK_PERIOD = 20;
    localparam int NCTR = 4;
    localparam logic [11:0] CTL_A = 12'h234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic [15:0] ev_i = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [31:0] m_cnt  [NCTR];
    logic [4:0]  m_code [NCTR];

    ecb_bank i_ecb_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .ev_i(ev_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] data_addr(int n);
        return 12'(12'h240 + 12'h00C * n);
    endfunction

    function automatic bit counts(logic [4:0] code, logic [15:0] ev);
        if (code == 5'd1) return 1'b1;
        if (code >= 5'd2 && code < 5'd16) return ev[code[3:0]];
        return 1'b0;
    endfunction

    function automatic logic [31:0] ctl_expect();
        logic [31:0] w = '0;
        for (int n = 0; n < NCTR; n++) w[n*8+1 +: 5] = m_code[n];
        return w;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        wr_en_i = 1'b0;
        addr_i  = a;
        #1;
        chk(rd_data_o, exp, tag);
    endtask

    task automatic check_all(input string tag);
        rd_check(CTL_A, ctl_expect(), "R2 control readback");
        for (int n = 0; n < NCTR; n++) rd_check(data_addr(n), m_cnt[n], tag);
    endtask

    // One clock with the given bus operation and strobes; model updated per requirements.
    task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d, input logic [15:0] ev);
        wr_en_i = wr; addr_i = a; wr_data_i = d; ev_i = ev;
        @(posedge clk);
        for (int n = 0; n < NCTR; n++) begin
            if (wr && a == data_addr(n)) m_cnt[n] = d;              // R8
            else if (counts(m_code[n], ev)) m_cnt[n] = m_cnt[n] + 1; // R4 R5 R7
        end
        if (wr && a == CTL_A)
            for (int n = 0; n < NCTR; n++) m_code[n] = d[n*8+1 +: 5];
        @(negedge clk);
        wr_en_i = 1'b0; ev_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < NCTR; n++) begin m_cnt[n] = '0; m_code[n] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_check(CTL_A, 32'h0, "R1 control after reset");
        for (int n = 0; n < NCTR; n++) rd_check(data_addr(n), 32'h0, "R1 count after reset");

        // R3 parked lanes ignore strobes
        for (int i = 0; i < 5; i++) step(0, 12'h0, 0, 16'hFFFF);
        check_all("R3 parked lane holds");

        // R2 field packing with junk in reserved bits; lane3 code 0x14 (R6 mute)
        step(1, CTL_A, {3'b111, 5'h14, 2'b11, 1'b1, 5'h00, 2'b11, 1'b1, 5'h0B, 2'b11, 1'b1, 5'h01, 1'b1}, 16'hFFFF);
        rd_check(CTL_A, 32'h2800_1602, "R2 packed fields only");
        chk(m_cnt[0], 32'h0, "R5 new code not active on write edge");
        for (int i = 0; i < 20; i++) step(0, 12'h0, 0, 16'($urandom));
        check_all("R5 selected strobe counted");
        rd_check(data_addr(3), 32'h0, "R6 mute code counts nothing");
        rd_check(data_addr(2), 32'h0, "R3 code zero idle");
        rd_check(data_addr(0), 32'd20, "R4 cycle code counts every edge");

        // R7 wrap
        step(1, data_addr(0), 32'hFFFF_FFFF, 16'h0);
        step(0, 12'h0, 0, 16'h0);
        rd_check(data_addr(0), 32'h0, "R7 wrap to zero");

        // R8 write beats event; R10 other lanes unaffected
        step(1, data_addr(1), 32'd5, 16'h0800);
        rd_check(data_addr(1), 32'd5, "R8 load wins over event");
        rd_check(data_addr(0), m_cnt[0], "R10 neighbour lane keeps counting");
        step(1, data_addr(0), 32'h0, 16'h0);
        rd_check(data_addr(0), 32'h0, "R8 zero write clears");

        // R9 unmapped space
        rd_check(12'h244, 32'h0, "R9 unmapped read");
        rd_check(12'h238, 32'h0, "R9 unmapped read");
        rd_check(12'h000, 32'h0, "R9 unmapped read");
        step(1, 12'h244, 32'hDEAD_BEEF, 16'h0);
        step(1, 12'h230, 32'hFFFF_FFFF, 16'h0);
        check_all("R9 unmapped write ignored");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            logic [15:0] ev = 16'($urandom);
            if (op == 0)      step(1, CTL_A, $urandom, ev);
            else if (op == 1) step(1, data_addr($urandom_range(0, NCTR-1)), $urandom, ev);
            else if (op == 2) step(1, data_addr($urandom_range(0, NCTR-1)), 32'hFFFF_FFFF - $urandom_range(0, 2), ev);
            else if (op == 3) step(1, 12'($urandom), $urandom, ev);
            else              step(0, 12'($urandom), 0, ev);
            r = $urandom;
            if (r[0]) check_all("R5 random counting");
            else check_all("R10 random lane independence");
        end
        finish_run();
    end
endmodule